// File: doc/BRIEF.md
# Burst-Aware Slave Port Arbiter

This block decides which of several masters owns one slave port of a crossbar. Each master presents a request, a flag saying whether its current access is an undefined-length incrementing burst, a beat-complete strobe and a final-beat marker. The arbiter answers with a registered one-hot grant. Single transfers and fixed-length bursts are handed over only at their boundaries, in round-robin order starting after the current owner.

While a master runs an undefined-length burst, a 3-bit policy field held for that master decides when the port may be taken away from it. The choices are: never, on every beat, or only once 4, 8 or 16 beats of the burst have completed. A small register port reads and writes these fields. It accepts only privileged 32-bit accesses and flags any other access as an error.

The control is a three-state machine. `IDLE` means no owner. `FIXED` means the owner is doing a single transfer or fixed burst. `UNDEF` means the owner is in an undefined-length burst. The transitions are:
- *grant-from-idle*: `IDLE` to `FIXED` or `UNDEF`.
- *release*: the owner drops its request, and the port goes to another requester or back to `IDLE`.
- *boundary*: a beat marked final, after which the port goes to another requester, or the owner keeps it and a new burst starts.
- *early handover*: `UNDEF` to a new owner at a policy-allowed beat.

Top module: `burst_port_arbiter`

## Requirements
- R1: After reset, the grant is all zero and every master's policy field reads 0.
- R2: From `IDLE`, the grant (at most one bit set) goes one cycle after a request to the first requesting master found searching upward from the previous owner plus one, wrapping; the reset pointer is master 0.
- R3: While the owner does a single transfer or fixed burst (burst flag 0), the grant does not change until it completes a beat with the final-beat marker set, or drops its request.
- R4: At any arbitration point, the port moves to the next requesting master after the owner in round-robin order; if no other master requests, the owner keeps the grant.
- R5: Policy code 0: an undefined-length burst (burst flag 1) is never interrupted before its final-marked beat.
- R6: Policy code 1: every completed beat of an undefined-length burst is an arbitration point.
- R7: Policy codes 2, 3 and 4: the beat that completes the 4th, 8th or 16th beat respectively is the first arbitration point, and every later beat is one too.
- R8: A write whose low three bits hold 5, 6 or 7 is ignored; the stored code is kept.
- R9: An access is accepted only with the privilege input high and size code 2'b10 (32-bit; 2'b00 is byte, 2'b01 is halfword). Any other access sets the error output in the next cycle and changes nothing. The field is bits 2:0 of the data word; write bits 31:3 are ignored and read back as zero.
- R10: The beat count restarts at zero whenever the grant changes hands or a new burst starts, including when the owner keeps the port at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MASTERS | Per-master port request |
| ulen_i | input | N_MASTERS | Per-master flag: current access is an undefined-length burst |
| beat_i | input | N_MASTERS | Per-master beat-complete strobe |
| last_i | input | N_MASTERS | Per-master final-beat marker, valid with beat |
| grant_o | output | N_MASTERS | One-hot grant, zero when idle |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_sup_i | input | 1 | Privileged (supervisor) access |
| reg_size_i | input | 2 | Access size code |
| reg_idx_i | input | IDX_W | Master whose field is addressed |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| reg_err_o | output | 1 | Error flag, valid the cycle after an access |

## Verification
The assertions assume a master holds its burst flag steady for the length of a burst. They also assume a beat strobe only arrives while the master is requesting. The bench keeps to both: it raises a burst flag before the request, never drops it mid-burst, and lowers requests only between bursts. The sweep covers every policy code with a competing requester present, checks each beat, and also reruns a burst in which the owner keeps the port, so that the counter restart is exercised.

// File: rtl/burst_arb_pkg.sv
package burst_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_UNDEF = 2'd2
    } arb_state_e;

    localparam int POL_W        = 3;
    localparam int POL_MAX_CODE = 4;
    localparam logic [1:0] SIZE_WORD = 2'b10;

    // Beats that must complete before the first allowed handover; 0 = never.
    function automatic int policy_threshold(input logic [POL_W-1:0] code);
        case (code)
            3'd1:    return 1;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd4:    return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/burst_arb_policy_regs.sv
module burst_arb_policy_regs
    import burst_arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             we_i,
    input  logic             sup_i,
    input  logic [1:0]       size_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic             err_o,
    input  logic [IDX_W-1:0] sel_i,
    output logic [POL_W-1:0] sel_pol_o
);

    logic [POL_W-1:0] pol_q [N_MASTERS];
    logic             acc_ok;
    logic             code_ok;

    assign acc_ok  = sup_i && (size_i == SIZE_WORD) && (int'(idx_i) < N_MASTERS);
    assign code_ok = (int'(wdata_i[POL_W-1:0]) <= POL_MAX_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < N_MASTERS; m++) pol_q[m] <= '0;
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            err_o   <= en_i && !acc_ok;
            rdata_o <= (en_i && !we_i && acc_ok) ? {{(32-POL_W){1'b0}}, pol_q[idx_i]} : '0;
            if (en_i && we_i && acc_ok && code_ok)
                pol_q[idx_i] <= wdata_i[POL_W-1:0];
        end
    end

    assign sel_pol_o = pol_q[sel_i];

    // R8
    reserved_write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && we_i && acc_ok && !code_ok) |=> pol_q[$past(idx_i)] == $past(pol_q[idx_i]));

    // R9
    bad_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (!sup_i || size_i != SIZE_WORD)) |=> err_o);

    // R9
    bad_access_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && we_i && !sup_i) |=> pol_q[$past(idx_i)] == $past(pol_q[idx_i]));

    // R9
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[31:POL_W] == '0);

endmodule

// File: rtl/burst_arb_rr_pick.sv
module burst_arb_rr_pick #(
    parameter int N_MASTERS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [IDX_W-1:0]     last_i,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 found_o
);

    // Scan from farthest to nearest so the nearest requester after last_i wins.
    always_comb begin
        idx_o   = last_i;
        found_o = 1'b0;
        for (int k = N_MASTERS; k >= 1; k--) begin
            int cand;
            cand = (int'(last_i) + k) % N_MASTERS;
            if (req_i[cand]) begin
                idx_o   = IDX_W'(cand);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/burst_arb_beat_cnt.sv
module burst_arb_beat_cnt #(
    parameter int MAX_BEATS = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= '0;
        else if (inc_i && int'(cnt_o) < MAX_BEATS)
            cnt_o <= cnt_o + 1'b1;
    end

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0);

    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_o) <= MAX_BEATS);

endmodule

// File: rtl/burst_port_arbiter.sv
module burst_port_arbiter
    import burst_arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int MAX_BEATS = 16,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] ulen_i,
    input  logic [N_MASTERS-1:0] beat_i,
    input  logic [N_MASTERS-1:0] last_i,
    output logic [N_MASTERS-1:0] grant_o,
    input  logic                 reg_en_i,
    input  logic                 reg_we_i,
    input  logic                 reg_sup_i,
    input  logic [1:0]           reg_size_i,
    input  logic [IDX_W-1:0]     reg_idx_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    output logic                 reg_err_o
);

    localparam int CNT_W = $clog2(MAX_BEATS + 1);

    arb_state_e       state_q, nxt_state;
    logic [IDX_W-1:0] owner_q, nxt_owner;
    logic             restart;

    logic [N_MASTERS-1:0] owner_oh;
    logic [N_MASTERS-1:0] others;
    logic                 own_req, own_beat, own_last;
    logic [IDX_W-1:0]     pick_all, pick_oth;
    logic                 any_req, any_oth;
    logic [POL_W-1:0]     own_pol;
    logic [CNT_W-1:0]     beat_cnt;
    logic                 arb_ok;
    int                   thr;

    always_comb begin
        owner_oh = '0;
        owner_oh[owner_q] = 1'b1;
    end

    assign others   = req_i & ~owner_oh;
    assign own_req  = req_i[owner_q];
    assign own_beat = beat_i[owner_q];
    assign own_last = last_i[owner_q];

    burst_arb_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) i_pick_all (
        .req_i   (req_i),
        .last_i  (owner_q),
        .idx_o   (pick_all),
        .found_o (any_req)
    );

    burst_arb_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) i_pick_oth (
        .req_i   (others),
        .last_i  (owner_q),
        .idx_o   (pick_oth),
        .found_o (any_oth)
    );

    burst_arb_policy_regs #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (reg_en_i),
        .we_i      (reg_we_i),
        .sup_i     (reg_sup_i),
        .size_i    (reg_size_i),
        .idx_i     (reg_idx_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .err_o     (reg_err_o),
        .sel_i     (owner_q),
        .sel_pol_o (own_pol)
    );

    burst_arb_beat_cnt #(.MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (restart),
        .inc_i (state_q == ST_UNDEF && own_beat),
        .cnt_o (beat_cnt)
    );

    assign thr    = policy_threshold(own_pol);
    assign arb_ok = (thr != 0) && (int'(beat_cnt) + 1 >= thr);

    // Next-state and handover decision
    always_comb begin
        nxt_state = state_q;
        nxt_owner = owner_q;
        restart   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) begin
                    nxt_owner = pick_all;
                    nxt_state = ulen_i[pick_all] ? ST_UNDEF : ST_FIXED;
                    restart   = 1'b1;
                end
            end
            ST_FIXED, ST_UNDEF: begin
                if (!own_req) begin
                    // release
                    restart = 1'b1;
                    if (any_oth) begin
                        nxt_owner = pick_oth;
                        nxt_state = ulen_i[pick_oth] ? ST_UNDEF : ST_FIXED;
                    end else begin
                        nxt_state = ST_IDLE;
                    end
                end else if (own_beat && own_last) begin
                    // boundary: hand over or start a new burst
                    restart = 1'b1;
                    if (any_oth) begin
                        nxt_owner = pick_oth;
                        nxt_state = ulen_i[pick_oth] ? ST_UNDEF : ST_FIXED;
                    end else begin
                        nxt_state = ulen_i[owner_q] ? ST_UNDEF : ST_FIXED;
                    end
                end else if (state_q == ST_UNDEF && own_beat && arb_ok && any_oth) begin
                    // early handover
                    restart   = 1'b1;
                    nxt_owner = pick_oth;
                    nxt_state = ulen_i[pick_oth] ? ST_UNDEF : ST_FIXED;
                end
            end
            default: begin
                nxt_state = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= nxt_state;
            owner_q <= nxt_owner;
        end
    end

    // Outputs
    always_comb begin
        grant_o = '0;
        if (state_q != ST_IDLE) grant_o[owner_q] = 1'b1;
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R3
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED && own_req && !(own_beat && own_last)) |=> $stable(grant_o));

    // R5
    never_policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNDEF && own_pol == 3'd0 && own_req && !(own_beat && own_last))
        |=> $stable(grant_o));

    // R7
    early_beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNDEF && own_pol >= 3'd2 && own_pol <= 3'd4 && beat_cnt == '0
         && own_req && !(own_beat && own_last)) |=> $stable(grant_o));

    // R4
    keep_when_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && own_req && others == '0) |=> $stable(grant_o));

endmodule

// File: tb/test_burst_port_arbiter.sv
`timescale 1ns/1ps
module test_burst_port_arbiter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0, ulen = '0, beat = '0, last = '0;
    logic [N-1:0] grant;
    logic         reg_en = 1'b0, reg_we = 1'b0, reg_sup = 1'b0;
    logic [1:0]   reg_size = 2'b10;
    logic [1:0]   reg_idx = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         reg_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    burst_port_arbiter #(.N_MASTERS(N)) i_burst_port_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ulen_i(ulen), .beat_i(beat),
        .last_i(last), .grant_o(grant), .reg_en_i(reg_en), .reg_we_i(reg_we),
        .reg_sup_i(reg_sup), .reg_size_i(reg_size), .reg_idx_i(reg_idx),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_err_o(reg_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] oh(input int m);
        return N'(1) << m;
    endfunction

    task automatic reg_access(input int idx, input bit we, input logic [31:0] data,
                              input bit sup, input logic [1:0] size);
        reg_en = 1'b1; reg_we = we; reg_idx = 2'(idx); reg_wdata = data;
        reg_sup = sup; reg_size = size;
        tick();
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic read_pol(input int idx, input logic [31:0] exp, input string tag);
        reg_access(idx, 1'b0, 32'h0, 1'b1, 2'b10);
        check(tag, reg_rdata, exp);
    endtask

    task automatic go_idle();
        req = '0; beat = '0; last = '0; ulen = '0;
        tick();
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 grant after reset", grant, 0);
        for (int m = 0; m < N; m++) read_pol(m, 0, "R1 policy after reset");

        // R9 register access rules
        reg_access(0, 1'b1, 32'hFFFF_FFFB, 1'b1, 2'b10);
        check("R9 good write err", reg_err, 0);
        read_pol(0, 3, "R9 field low bits, upper read zero");
        reg_access(0, 1'b1, 32'h4, 1'b0, 2'b10);
        check("R9 unprivileged write err", reg_err, 1);
        read_pol(0, 3, "R9 unprivileged write ignored");
        reg_access(0, 1'b1, 32'h4, 1'b1, 2'b00);
        check("R9 byte write err", reg_err, 1);
        read_pol(0, 3, "R9 byte write ignored");
        reg_access(0, 1'b1, 32'h1, 1'b1, 2'b01);
        check("R9 halfword write err", reg_err, 1);
        reg_access(0, 1'b0, 32'h0, 1'b0, 2'b10);
        check("R9 unprivileged read err", reg_err, 1);
        check("R9 unprivileged read data", reg_rdata, 0);

        // R8 reserved codes
        for (int c = 5; c < 8; c++) begin
            reg_access(0, 1'b1, 32'(c), 1'b1, 2'b10);
            check("R8 reserved write no err", reg_err, 0);
            read_pol(0, 3, "R8 reserved write ignored");
        end
        reg_access(0, 1'b1, 32'h0, 1'b1, 2'b10);

        // R2 grant from idle, pointer starts after master 0
        req = 4'b0110;
        tick();
        check("R2 idle grant to next after pointer", grant, oh(1));
        // R3 fixed burst held until final beat
        for (int k = 0; k < 3; k++) begin
            beat[1] = 1'b1;
            tick();
            check("R3 fixed burst not interrupted", grant, oh(1));
        end
        last[1] = 1'b1;
        tick();
        check("R3 handover at final beat", grant, oh(2));
        beat = '0; last = '0;
        go_idle();
        check("R3 release to idle", grant, 0);

        // R4 round robin with all requesting single transfers
        req = '1; beat = '1; last = '1;
        begin
            int exp_m;
            exp_m = 3;
            for (int k = 0; k < 8; k++) begin
                tick();
                check("R4 round robin order", grant, oh(exp_m));
                exp_m = (exp_m + 1) % N;
            end
        end
        go_idle();

        // R5 R6 R7 R10 policy sweep, master 0 bursting, master 1 waiting
        for (int c = 0; c <= 4; c++) begin
            int thr;
            bit done;
            thr = (c == 0) ? 1000 : (c == 1) ? 1 : (1 << c);
            reg_access(0, 1'b1, 32'(c), 1'b1, 2'b10);
            ulen[0] = 1'b1; req[0] = 1'b1;
            tick();
            check("R2 sweep owner", grant, oh(0));
            req[1] = 1'b1;
            done = 1'b0;
            for (int k = 1; k <= 20 && !done; k++) begin
                beat[0] = 1'b1;
                tick();
                if (c == 0)      check("R5 no handover in burst", grant, oh(k >= thr ? 1 : 0));
                else if (c == 1) check("R6 handover every beat", grant, oh(k >= thr ? 1 : 0));
                else             check("R7 R10 handover after threshold", grant, oh(k >= thr ? 1 : 0));
                if (k >= thr) done = 1'b1;
            end
            if (c == 0) begin
                last[0] = 1'b1;
                tick();
                check("R5 handover at final beat", grant, oh(1));
            end
            go_idle();
        end

        // R4 keep when alone, R10 restart on new burst
        reg_access(0, 1'b1, 32'h2, 1'b1, 2'b10);
        ulen[0] = 1'b1; req[0] = 1'b1;
        tick();
        for (int k = 0; k < 6; k++) begin
            beat[0] = 1'b1;
            tick();
            check("R4 owner keeps with no competitor", grant, oh(0));
        end
        last[0] = 1'b1;
        tick();
        check("R4 owner keeps at boundary", grant, oh(0));
        last[0] = 1'b0; beat[0] = 1'b0;
        req[1] = 1'b1;
        tick();
        for (int k = 1; k <= 4; k++) begin
            beat[0] = 1'b1;
            tick();
            check("R10 count restarts on new burst", grant, oh(k >= 4 ? 1 : 0));
        end
        go_idle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule